// File: doc/BRIEF.md
# Adaptive On-Time PWM Sequencer

This block sequences the two gate-enable signals of a synchronous buck power stage. An external comparator reports, as a single digital input, whether the regulated feedback has fallen below its reference. When that happens and the stage has rested long enough, the sequencer opens a high-side conduction window. The length of that window is an estimate of the nominal switching period scaled by the ratio of output to input voltage. Both voltages arrive as digitized codes. Above a ceiling, the input code is clamped before the division, so very high input voltages stretch the effective period instead of shrinking the pulse further.

Between pulses the low-side enable conducts until feedback drops again. The off interval is subject to a floor, so that the high side can never be re-fired too quickly. Every change of conduction between the two switches passes through a fixed dead interval in which both enables are low. All timing is counted in cycles of a fast system clock. With the default parameters (100 MHz clock), the period is 333 cycles, the minimum high-side-off interval is 36 cycles and the dead interval is 3 cycles. Voltage codes have a step of 0.25 V, so the clamp code 120 stands for 30 V.

The control is a five-state machine:
- S_IDLE: both enables low.
- S_GAP_LS: dead interval ahead of low-side conduction.
- S_LS_ON: low-side enable high.
- S_GAP_HS: dead interval ahead of high-side conduction.
- S_HS_ON: high-side enable high.

Its transitions are:
- arm: S_IDLE to S_GAP_LS, when enabled.
- settle: S_GAP_LS to S_LS_ON, after DEAD_CYC cycles.
- trigger: S_LS_ON to S_GAP_HS, when feedback is low and the low-side phase has lasted MIN_OFF_CYC − 2·DEAD_CYC cycles.
- fire: S_GAP_HS to S_HS_ON, after DEAD_CYC cycles.
- expire: S_HS_ON to S_GAP_LS, after the latched on-time.
- halt: any state to S_IDLE, when the enable input is low.

Top module: `aot_pwm_seq`

## Requirements
- R1: A synchronous active-low reset puts the machine in S_IDLE, so both hs_en and ls_en are low on the cycle after reset is sampled low.
- R2: When run_en is sampled low, both enables are low on the next cycle. After run_en is sampled high from S_IDLE, ls_en rises after DEAD_CYC further cycles with both enables low.
- R3: A high-side pulse begins (hs_en rises) DEAD_CYC+1 cycles after fb_low is sampled high in S_LS_ON. This requires the low-side phase to have lasted at least MIN_OFF_CYC − 2·DEAD_CYC cycles, so hs_en stays low for at least MIN_OFF_CYC cycles between pulses.
- R4: The high-side pulse lasts floor(PERIOD_CYC·vout_code / vin_eff) cycles, bounded below by 1 and above by PERIOD_CYC. Here vin_eff is the clamped input code, or 1 when that code is 0.
- R5: vin_eff equals min(vin_code, VIN_CLAMP_CODE). Any input code above the clamp gives the same pulse as the clamp value.
- R6: Each transition between high-side and low-side conduction inserts exactly DEAD_CYC cycles with both enables low. hs_en and ls_en are never high together.
- R7: While fb_low stays high, pulses repeat back to back, with hs_en low for exactly MIN_OFF_CYC cycles between them.
- R8: The on-time is taken from the estimate registered one cycle before the fire transition. A change of the voltage codes during a pulse leaves that pulse unchanged and sets the width of the next one.
- R9: While fb_low stays low, the sequencer holds S_LS_ON and no high-side pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Enable; low forces both gate enables off |
| fb_low | input | 1 | Comparator: feedback below reference |
| vin_code | input | VCODE_W | Digitized input voltage (0.25 V per step by default) |
| vout_code | input | VCODE_W | Digitized output voltage (same scale) |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
On every cycle, the assertions check that the two enables never overlap, and that each high-side turn-on follows exactly the dead interval. They also check that the high-side-off interval before a pulse meets its floor, that no pulse exceeds the period, and that disable and reset force both enables low. The exact pulse width for given voltage codes, the input clamp, and the latching of codes at pulse start can only be shown by the bench's scenarios. The same holds for the trigger latency from the feedback input. The bench compares its behavioural model against the outputs on every clock, while stepping through those cases.

// File: rtl/aot_pkg.sv
package aot_pkg;
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_GAP_LS = 3'd1,
        S_LS_ON  = 3'd2,
        S_GAP_HS = 3'd3,
        S_HS_ON  = 3'd4
    } phase_t;
endpackage

// File: rtl/aot_ton_est.sv
module aot_ton_est #(
    parameter int PERIOD_CYC     = 333,
    parameter int VCODE_W        = 8,
    parameter int VIN_CLAMP_CODE = 120,
    parameter int CNT_W          = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VCODE_W-1:0] vin_code,
    input  logic [VCODE_W-1:0] vout_code,
    output logic [CNT_W-1:0]   ton_est_q
);
    localparam int PROD_W = VCODE_W + CNT_W;

    logic [VCODE_W-1:0] vin_eff;
    logic [PROD_W-1:0]  product;
    logic [PROD_W-1:0]  quotient;
    logic [CNT_W-1:0]   ton_d;

    always_comb begin
        // R5: saturate the input code before it enters the divide
        if (vin_code > VCODE_W'(VIN_CLAMP_CODE)) begin
            vin_eff = VCODE_W'(VIN_CLAMP_CODE);
        end else if (vin_code == '0) begin
            vin_eff = VCODE_W'(1);
        end else begin
            vin_eff = vin_code;
        end
        product  = PROD_W'(PERIOD_CYC) * PROD_W'(vout_code);
        quotient = product / PROD_W'(vin_eff);
        if (quotient == '0) begin
            ton_d = CNT_W'(1);
        end else if (quotient > PROD_W'(PERIOD_CYC)) begin
            ton_d = CNT_W'(PERIOD_CYC);
        end else begin
            ton_d = quotient[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ton_est_q <= CNT_W'(1);
        end else begin
            ton_est_q <= ton_d;
        end
    end
endmodule

// File: rtl/aot_phase_fsm.sv
module aot_phase_fsm
    import aot_pkg::*;
#(
    parameter int MIN_OFF_CYC = 36,
    parameter int DEAD_CYC    = 3,
    parameter int CNT_W       = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             fb_low,
    input  logic [CNT_W-1:0] ton_est,
    output logic             hs_en,
    output logic             ls_en
);
    localparam int LS_MIN  = MIN_OFF_CYC - 2 * DEAD_CYC;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    phase_t           state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ton_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   state_d = S_GAP_LS;
            S_GAP_LS: if (cnt_q == CNT_W'(DEAD_CYC - 1)) state_d = S_LS_ON;
            S_LS_ON:  if (fb_low && cnt_q >= CNT_W'(LS_MIN - 1)) state_d = S_GAP_HS;
            S_GAP_HS: if (cnt_q == CNT_W'(DEAD_CYC - 1)) state_d = S_HS_ON;
            S_HS_ON:  if (cnt_q == ton_q - CNT_W'(1)) state_d = S_GAP_LS;
        endcase
        if (!run_en) begin
            state_d = S_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            ton_q   <= CNT_W'(1);
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (cnt_q != CNT_W'(CNT_MAX)) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            // R8: the width is fixed at the fire transition
            if (state_q == S_GAP_HS && state_d == S_HS_ON) begin
                ton_q <= ton_est;
            end
        end
    end

    always_comb begin
        hs_en = 1'b0;
        ls_en = 1'b0;
        unique case (state_q)
            S_HS_ON: hs_en = 1'b1;
            S_LS_ON: ls_en = 1'b1;
            S_IDLE, S_GAP_LS, S_GAP_HS: ;
        endcase
    end
endmodule

// File: rtl/aot_pwm_seq.sv
module aot_pwm_seq #(
    parameter int PERIOD_CYC     = 333,
    parameter int MIN_OFF_CYC    = 36,
    parameter int DEAD_CYC       = 3,
    parameter int VCODE_W        = 8,
    parameter int VIN_CLAMP_CODE = 120
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               fb_low,
    input  logic [VCODE_W-1:0] vin_code,
    input  logic [VCODE_W-1:0] vout_code,
    output logic               hs_en,
    output logic               ls_en
);
    localparam int LIMIT = (PERIOD_CYC > MIN_OFF_CYC) ? PERIOD_CYC : MIN_OFF_CYC;
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] ton_est;

    aot_ton_est #(
        .PERIOD_CYC    (PERIOD_CYC),
        .VCODE_W       (VCODE_W),
        .VIN_CLAMP_CODE(VIN_CLAMP_CODE),
        .CNT_W         (CNT_W)
    ) i_ton_est (
        .clk      (clk),
        .rst_n    (rst_n),
        .vin_code (vin_code),
        .vout_code(vout_code),
        .ton_est_q(ton_est)
    );

    aot_phase_fsm #(
        .MIN_OFF_CYC(MIN_OFF_CYC),
        .DEAD_CYC   (DEAD_CYC),
        .CNT_W      (CNT_W)
    ) i_phase_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_en),
        .fb_low (fb_low),
        .ton_est(ton_est),
        .hs_en  (hs_en),
        .ls_en  (ls_en)
    );
endmodule

// File: rtl/aot_pwm_seq_chk.sv
module aot_pwm_seq_chk #(
    parameter int PERIOD_CYC  = 333,
    parameter int MIN_OFF_CYC = 36,
    parameter int DEAD_CYC    = 3
) (
    input logic clk,
    input logic rst_n,
    input logic run_en,
    input logic hs_en,
    input logic ls_en
);
    localparam int LIMIT = (PERIOD_CYC > MIN_OFF_CYC) ? PERIOD_CYC : MIN_OFF_CYC;
    localparam int RUN_W = $clog2(LIMIT + 1) + 1;
    localparam int SAT   = (1 << RUN_W) - 1;

    logic [RUN_W-1:0] gap_q, off_q, on_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
            off_q <= '0;
            on_q  <= '0;
        end else begin
            gap_q <= (!hs_en && !ls_en) ? ((gap_q == RUN_W'(SAT)) ? gap_q : gap_q + RUN_W'(1)) : '0;
            off_q <= !hs_en ? ((off_q == RUN_W'(SAT)) ? off_q : off_q + RUN_W'(1)) : '0;
            on_q  <= hs_en ? ((on_q == RUN_W'(SAT)) ? on_q : on_q + RUN_W'(1)) : '0;
        end
    end

    assert_reset_off_R1: assert property (@(posedge clk)
        !rst_n |=> (!hs_en && !ls_en));

    assert_disable_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!hs_en && !ls_en));

    assert_off_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> (off_q >= RUN_W'(MIN_OFF_CYC)));

    assert_pulse_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en |-> (on_q < RUN_W'(PERIOD_CYC)));

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    assert_hs_dead_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> (gap_q == RUN_W'(DEAD_CYC)));

    assert_ls_dead_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> (gap_q >= RUN_W'(DEAD_CYC)));
endmodule

bind aot_pwm_seq aot_pwm_seq_chk #(
    .PERIOD_CYC (PERIOD_CYC),
    .MIN_OFF_CYC(MIN_OFF_CYC),
    .DEAD_CYC   (DEAD_CYC)
) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .run_en(run_en),
    .hs_en (hs_en),
    .ls_en (ls_en)
);

// File: tb/test_aot_pwm_seq.sv
module test_aot_pwm_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PERIOD     = 333;
    localparam int MIN_OFF    = 36;
    localparam int DEAD       = 3;
    localparam int CLAMP      = 120;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       fb_low = 1'b0;
    logic [7:0] vin_code = 8'd48;
    logic [7:0] vout_code = 8'd13;
    logic       hs_en, ls_en;

    int n_checks = 0;
    int n_err    = 0;

    aot_pwm_seq i_aot_pwm_seq (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .fb_low(fb_low),
        .vin_code(vin_code), .vout_code(vout_code),
        .hs_en(hs_en), .ls_en(ls_en)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int exp_ton(int vi, int vo);
        int c = (vi > CLAMP) ? CLAMP : vi;
        int q;
        if (c == 0) c = 1;
        q = PERIOD * vo / c;
        if (q < 1) q = 1;
        if (q > PERIOD) q = PERIOD;
        return q;
    endfunction

    task automatic chk(string tag, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: phase code plus countdowns
    int m_ph = 0;       // 0 idle, 1 gap before low, 2 low, 3 gap before high, 4 high
    int m_rem = 0;
    int m_low = 0;
    int m_est = 1;
    bit m_live = 0;

    always @(posedge clk) begin
        int nxt_est;
        m_live = 1;
        nxt_est = exp_ton(vin_code, vout_code);
        if (!rst_n) begin
            m_ph = 0; m_est = 1;
        end else begin
            if (!run_en) begin
                m_ph = 0;
            end else begin
                case (m_ph)
                    0: begin m_ph = 1; m_rem = DEAD; end
                    1: begin m_rem--; if (m_rem == 0) begin m_ph = 2; m_low = 0; end end
                    2: begin m_low++; if (fb_low && m_low >= MIN_OFF - 2 * DEAD) begin m_ph = 3; m_rem = DEAD; end end
                    3: begin m_rem--; if (m_rem == 0) begin m_ph = 4; m_rem = m_est; end end
                    default: begin m_rem--; if (m_rem == 0) begin m_ph = 1; m_rem = DEAD; end end
                endcase
            end
            m_est = nxt_est;
        end
    end

    always @(negedge clk) begin
        if (m_live) begin
            string tag;
            case (m_ph)
                0: tag = "R2";
                2: tag = "R9";
                4: tag = "R4";
                default: tag = "R6";
            endcase
            chk(tag, int'({hs_en, ls_en}), int'({m_ph == 4, m_ph == 2}), "per-cycle {hs,ls}");
        end
    end

    task automatic wait_hs(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!hs_en && n < 5000);
    endtask

    task automatic width_hs(output int w);
        w = 1;
        forever begin
            @(negedge clk);
            if (hs_en) w++; else break;
        end
    endtask

    task automatic gap_to_ls(output int n);
        n = 0;
        while (!ls_en && n < 5000) begin n++; @(negedge clk); end
    endtask

    task automatic one_pulse(string tag, int exp_w);
        int n, w;
        repeat (MIN_OFF + 4) @(negedge clk);
        fb_low = 1'b1;
        wait_hs(n);
        fb_low = 1'b0;
        chk("R3", n, DEAD + 1, "trigger latency");
        width_hs(w);
        chk(tag, w, exp_w, "pulse width");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        int n, w, hcount;
        repeat (3) @(negedge clk);
        chk("R1", int'({hs_en, ls_en}), 0, "outputs in reset");
        rst_n = 1'b1;
        @(negedge clk);
        run_en = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!ls_en && n < 100);
        chk("R2", n, DEAD + 1, "enable to low-side latency");

        // R9: feedback never low, no pulse
        hcount = 0;
        repeat (200) begin @(negedge clk); if (hs_en) hcount++; end
        chk("R9", hcount, 0, "high-side cycles with feedback high");

        // R4 nominal 12 V -> 3.25 V, and R6 dead time after the pulse
        one_pulse("R4", exp_ton(48, 13));
        chk("R4", exp_ton(48, 13), 90, "formula sanity");
        gap_to_ls(n);
        chk("R6", n, DEAD, "dead cycles high-to-low");

        // R5 clamp
        vout_code = 8'd40; vin_code = 8'd160;
        one_pulse("R5", 111);
        vin_code = 8'd120;
        one_pulse("R5", 111);
        vin_code = 8'd100;
        one_pulse("R4", 133);

        // R4 bounds
        vout_code = 8'd0; vin_code = 8'd48;
        one_pulse("R4", 1);
        vout_code = 8'd200; vin_code = 8'd40;
        one_pulse("R4", PERIOD);

        // R7 back-to-back
        vout_code = 8'd13; vin_code = 8'd48;
        repeat (MIN_OFF + 4) @(negedge clk);
        fb_low = 1'b1;
        wait_hs(n);
        for (int k = 0; k < 3; k++) begin
            width_hs(w);
            chk("R7", w, 90, "back-to-back width");
            wait_hs(n);
            chk("R7", n, MIN_OFF, "high-side-off interval");
        end
        fb_low = 1'b0;
        width_hs(w);

        // R8 code change in mid-pulse
        repeat (MIN_OFF + 4) @(negedge clk);
        fb_low = 1'b1;
        wait_hs(n);
        fb_low = 1'b0;
        repeat (10) @(negedge clk);
        vout_code = 8'd26;
        width_hs(w);
        chk("R8", w + 10, 90, "width of pulse in flight");
        one_pulse("R8", exp_ton(48, 26));

        // R2 disable during a pulse
        repeat (MIN_OFF + 4) @(negedge clk);
        fb_low = 1'b1;
        wait_hs(n);
        fb_low = 1'b0;
        repeat (5) @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        chk("R2", int'({hs_en, ls_en}), 0, "outputs after disable");
        repeat (4) @(negedge clk);
        run_en = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!ls_en && n < 100);
        chk("R2", n, DEAD + 1, "re-enable to low-side latency");

        // R1 reset while running
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", int'({hs_en, ls_en}), 0, "outputs after mid-run reset");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule